// File: doc/BRIEF.md
# Command Ring Fetch Unit

The unit is the front end of a command processor. The host places 32-bit command words in a circular buffer in memory. It then announces the new tail by writing a write-pointer register. The unit keeps its own read pointer. Whenever the two pointers differ, it reads words from the buffer one at a time, in address order. After the last slot it continues at slot zero. Each word goes into a small prefetch queue, and a downstream consumer drains the queue over a valid/ready stream.

Both pointers index 32-bit words, not bytes. The ring holds a power-of-two number of words, so every pointer is reduced modulo the ring size. The write-pointer register also carries a completion flag in its top bit, and that flag is stored apart from the pointer value.

The host can observe several things:
- the read pointer;
- the stored write pointer and the completion flag;
- a status word that gives the prefetch occupancy and two activity flags;
- the number of free slots it may still fill.

The memory side is a plain read port with a fixed latency of one cycle.

Stream rules for the consumer:
- A word is transferred on every cycle in which `cmd_valid_o` and `cmd_ready_i` are both high.
- While `cmd_valid_o` is high and `cmd_ready_i` is low, the offered word holds.
- When the consumer stalls, the prefetch queue fills. The unit then stops issuing memory reads until space is freed.

Top module: `cmd_ring_fetch`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the read pointer, the write pointer and the completion flag. It also empties the prefetch queue and cancels any read in flight, so after the edge `status_o` is 0 and `cmd_valid_o` is low.
- R2: When `wptr_we` is high at a clock edge, the stored write pointer takes `wptr_wdata[RING_AW-1:0]` and the completion flag takes `wptr_wdata[31]`. Bits RING_AW to 30 are ignored. Setting only the flag, with an unchanged pointer, starts no fetch.
- R3: In any cycle where the read pointer differs from the write pointer and the queue has room, `mem_rd_en_o` is high and `mem_addr_o` equals the read pointer. On the next edge the read pointer moves on by one word. When the pointers are equal, no read is issued and the read pointer holds.
- R4: The word on `mem_rdata_i` one cycle after a read is entered into the queue. Words reach the stream in the order of the addresses read.
- R5: The read pointer wraps from RING_WORDS-1 to 0.
- R6: `cmd_valid_o` is high exactly when the queue holds a word, and `cmd_data_o` is the oldest word held. The queue drops that word only on a cycle with `cmd_valid_o` and `cmd_ready_i` both high. While the stream is stalled, the valid flag and the data hold.
- R7: A read is issued only when the queue occupancy plus the reads in flight is below FIFO_DEPTH. With the consumer stalled, the queue therefore fills to exactly FIFO_DEPTH words and never overflows.
- R8: The fields of `status_o` are:
  - bits 11:0 hold the queue occupancy;
  - bit 16 (busy) is high while the pointers differ or the queue is not empty;
  - bit 31 (fetch pending) is high while the pointers differ;
  - all other bits are 0.
- R9: `free_words_o` equals (read pointer − write pointer) modulo RING_WORDS. A result of zero is reported as RING_WORDS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wptr_we | input | 1 | Host write strobe for the write-pointer register |
| wptr_wdata | input | 32 | Host write data: pointer in the low bits, completion flag in bit 31 |
| rptr_o | output | RING_AW | Current read pointer, in words |
| wptr_o | output | RING_AW | Stored write pointer, in words |
| done_o | output | 1 | Stored completion flag |
| status_o | output | 32 | Queue count, busy flag and fetch-pending flag |
| free_words_o | output | RING_AW+1 | Free ring slots as seen by the host |
| mem_rd_en_o | output | 1 | Memory read request |
| mem_addr_o | output | RING_AW | Word address of the read |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the request |
| cmd_valid_o | output | 1 | Stream valid |
| cmd_ready_i | input | 1 | Stream ready |
| cmd_data_o | output | 32 | Stream command word |

## Verification
The bound properties check, on every cycle:
- queue-room safety at each read issue;
- the one-word step of the read pointer and its hold when no read is issued;
- the hold of the stream under back-pressure;
- the loading of the write-pointer register and its flag;
- the range of the free count;
- the state after reset.

Only the bench's scenarios can show the rest. These are the exact order and content of delivered words across a wrap, the queue settling at full under a long stall and draining afterwards, and the handling of ignored high bits and of flag-only writes. They also cover a reset arriving mid-stream. The bench runs a behavioural reference model beside the design and compares every output on every clock.

// File: rtl/cmdr_pkg.sv
package cmdr_pkg;
  localparam int STAT_CNT_W      = 12;
  localparam int STAT_BUSY_BIT   = 16;
  localparam int STAT_ACTIVE_BIT = 31;
  localparam int WPTR_DONE_BIT   = 31;
  localparam int WORD_W          = 32;
endpackage

// File: rtl/cmdr_fifo.sv
module cmdr_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty
);
  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] wr_idx, rd_idx;
  logic          do_pop;

  assign empty  = (count == '0);
  assign do_pop = pop && !empty;
  assign head   = store[rd_idx];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] idx);
    if (idx == AW'(DEPTH - 1)) return '0;
    return idx + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wr_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_idx <= step(wr_idx);
      if (do_pop) rd_idx <= step(rd_idx);
      case ({push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cmdr_fetch_ctl.sv
module cmdr_fetch_ctl #(
  parameter int RING_AW = 8,
  parameter int DEPTH   = 16,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wptr_we,
  input  logic [31:0]        wptr_wdata,
  input  logic [CW-1:0]      fifo_count,
  output logic [RING_AW-1:0] rptr,
  output logic [RING_AW-1:0] wptr,
  output logic               done,
  output logic               rd_en,
  output logic [RING_AW-1:0] rd_addr,
  output logic               inflight
);
  import cmdr_pkg::*;

  localparam logic [CW:0] DEPTH_V = (CW + 1)'(DEPTH);

  logic [CW:0] committed;
  logic        pending;

  assign pending   = (rptr != wptr);
  assign committed = {1'b0, fifo_count} + {{CW{1'b0}}, inflight};
  assign rd_en     = pending && (committed < DEPTH_V);
  assign rd_addr   = rptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      done <= 1'b0;
    end else if (wptr_we) begin
      wptr <= wptr_wdata[RING_AW-1:0];
      done <= wptr_wdata[WPTR_DONE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr     <= '0;
      inflight <= 1'b0;
    end else begin
      inflight <= rd_en;
      if (rd_en) rptr <= rptr + 1'b1;
    end
  end
endmodule

// File: rtl/cmdr_status.sv
module cmdr_status #(
  parameter int RING_AW = 8,
  parameter int CW      = 5
) (
  input  logic [RING_AW-1:0] rptr,
  input  logic [RING_AW-1:0] wptr,
  input  logic [CW-1:0]      fifo_count,
  output logic [31:0]        status,
  output logic [RING_AW:0]   free_words
);
  import cmdr_pkg::*;

  localparam logic [RING_AW:0] RING_WORDS = {1'b1, {RING_AW{1'b0}}};

  logic [RING_AW-1:0]    diff;
  logic [STAT_CNT_W-1:0] cnt_field;

  generate
    if (CW <= STAT_CNT_W) begin : g_cnt_ext
      assign cnt_field = STAT_CNT_W'(fifo_count);
    end else begin : g_cnt_sat
      assign cnt_field = (fifo_count > CW'({STAT_CNT_W{1'b1}})) ?
                         {STAT_CNT_W{1'b1}} : fifo_count[STAT_CNT_W-1:0];
    end
  endgenerate

  assign diff       = rptr - wptr;
  assign free_words = (diff == '0) ? RING_WORDS : {1'b0, diff};

  always_comb begin
    status                    = '0;
    status[STAT_CNT_W-1:0]    = cnt_field;
    status[STAT_BUSY_BIT]     = (rptr != wptr) || (fifo_count != '0);
    status[STAT_ACTIVE_BIT]   = (rptr != wptr);
  end
endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch #(
  parameter int RING_AW    = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wptr_we,
  input  logic [31:0]        wptr_wdata,
  output logic [RING_AW-1:0] rptr_o,
  output logic [RING_AW-1:0] wptr_o,
  output logic               done_o,
  output logic [31:0]        status_o,
  output logic [RING_AW:0]   free_words_o,
  output logic               mem_rd_en_o,
  output logic [RING_AW-1:0] mem_addr_o,
  input  logic [31:0]        mem_rdata_i,
  output logic               cmd_valid_o,
  input  logic               cmd_ready_i,
  output logic [31:0]        cmd_data_o
);
  import cmdr_pkg::*;

  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [CW-1:0] fifo_count;
  logic          fifo_empty;
  logic          inflight;

  cmdr_fetch_ctl #(.RING_AW(RING_AW), .DEPTH(FIFO_DEPTH)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .wptr_we    (wptr_we),
    .wptr_wdata (wptr_wdata),
    .fifo_count (fifo_count),
    .rptr       (rptr_o),
    .wptr       (wptr_o),
    .done       (done_o),
    .rd_en      (mem_rd_en_o),
    .rd_addr    (mem_addr_o),
    .inflight   (inflight)
  );

  cmdr_fifo #(.DW(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (inflight),
    .push_data (mem_rdata_i),
    .pop       (cmd_ready_i),
    .head      (cmd_data_o),
    .count     (fifo_count),
    .empty     (fifo_empty)
  );

  assign cmd_valid_o = !fifo_empty;

  cmdr_status #(.RING_AW(RING_AW), .CW(CW)) u_stat (
    .rptr       (rptr_o),
    .wptr       (wptr_o),
    .fifo_count (fifo_count),
    .status     (status_o),
    .free_words (free_words_o)
  );
endmodule

// File: rtl/cmdr_checker.sv
module cmdr_checker #(
  parameter int RING_AW    = 8,
  parameter int FIFO_DEPTH = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               wptr_we,
  input logic [31:0]        wptr_wdata,
  input logic [RING_AW-1:0] rptr_o,
  input logic [RING_AW-1:0] wptr_o,
  input logic               done_o,
  input logic [31:0]        status_o,
  input logic [RING_AW:0]   free_words_o,
  input logic               mem_rd_en_o,
  input logic               cmd_valid_o,
  input logic               cmd_ready_i,
  input logic [31:0]        cmd_data_o
);
  localparam logic [11:0]      DEPTH12    = 12'(FIFO_DEPTH);
  localparam logic [RING_AW:0] RING_WORDS = {1'b1, {RING_AW{1'b0}}};

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (rptr_o == '0) && (wptr_o == '0) && !done_o && !cmd_valid_o && (status_o == '0));

  p_wptr_load_r2: assert property (@(posedge clk) disable iff (rst)
    wptr_we |=> (wptr_o == $past(wptr_wdata[RING_AW-1:0])) && (done_o == $past(wptr_wdata[31])));

  p_idle_no_read_r3: assert property (@(posedge clk) disable iff (rst)
    (rptr_o == wptr_o) |-> !mem_rd_en_o);

  p_rptr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_en_o |=> $stable(rptr_o));

  p_rptr_step_r5: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en_o |=> (rptr_o == RING_AW'($past(rptr_o) + 1'b1)));

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_data_o)));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en_o |-> (status_o[11:0] < DEPTH12));

  p_busy_when_valid_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> status_o[16]);

  p_free_range_r9: assert property (@(posedge clk) disable iff (rst)
    (free_words_o != '0) && (free_words_o <= RING_WORDS));
endmodule

bind cmd_ring_fetch cmdr_checker #(.RING_AW(RING_AW), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wptr_we      (wptr_we),
  .wptr_wdata   (wptr_wdata),
  .rptr_o       (rptr_o),
  .wptr_o       (wptr_o),
  .done_o       (done_o),
  .status_o     (status_o),
  .free_words_o (free_words_o),
  .mem_rd_en_o  (mem_rd_en_o),
  .cmd_valid_o  (cmd_valid_o),
  .cmd_ready_i  (cmd_ready_i),
  .cmd_data_o   (cmd_data_o)
);

// File: tb/cmd_ring_fetch_bench.sv
module cmd_ring_fetch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RAW        = 8;
  localparam int RING       = 256;
  localparam int DEPTH      = 16;
  localparam int WATCHDOG   = 20000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wptr_we = 1'b0;
  logic [31:0]    wptr_wdata = '0;
  logic           cmd_ready = 1'b0;
  logic [31:0]    mem_rdata = '0;
  logic [RAW-1:0] rptr_o, wptr_o, mem_addr;
  logic           done_o, mem_rd_en, cmd_valid;
  logic [31:0]    status_o, cmd_data;
  logic [RAW:0]   free_words;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cmd_ring_fetch #(.RING_AW(RAW), .FIFO_DEPTH(DEPTH)) u_cmd_ring_fetch (
    .clk(clk), .rst(rst), .wptr_we(wptr_we), .wptr_wdata(wptr_wdata),
    .rptr_o(rptr_o), .wptr_o(wptr_o), .done_o(done_o), .status_o(status_o),
    .free_words_o(free_words), .mem_rd_en_o(mem_rd_en), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_data_o(cmd_data)
  );

  function automatic logic [31:0] word_at(input int a);
    return {16'hC0DE ^ 16'(a * 37), 16'(a)};
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= word_at(int'(mem_addr));

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int          m_rptr = 0, m_wptr = 0, m_iaddr = 0;
  bit          m_done = 0, m_infl = 0, armed = 0;
  logic [31:0] m_q[$];

  always @(negedge clk) begin
    bit          e_rd, e_valid, e_pend;
    logic [31:0] e_stat;
    int          e_free;
    e_pend  = (m_rptr != m_wptr);
    e_rd    = e_pend && ((m_q.size() + int'(m_infl)) < DEPTH);
    e_valid = (m_q.size() > 0);
    e_stat  = 32'(m_q.size());
    e_stat[16] = e_pend || e_valid;
    e_stat[31] = e_pend;
    e_free  = (m_rptr - m_wptr + RING) % RING;
    if (e_free == 0) e_free = RING;
    if (armed) begin
      check("R2", "wptr_o", 32'(wptr_o), 32'(m_wptr));
      check("R2", "done_o", 32'(done_o), 32'(m_done));
      check("R5", "rptr_o", 32'(rptr_o), 32'(m_rptr));
      if (e_pend && !e_rd) check("R7", "mem_rd_en_o", 32'(mem_rd_en), 32'(e_rd));
      else                 check("R3", "mem_rd_en_o", 32'(mem_rd_en), 32'(e_rd));
      if (e_rd) check("R3", "mem_addr_o", 32'(mem_addr), 32'(m_rptr));
      check("R6", "cmd_valid_o", 32'(cmd_valid), 32'(e_valid));
      if (e_valid) check("R4", "cmd_data_o", cmd_data, m_q[0]);
      check("R8", "status_o", status_o, e_stat);
      check("R9", "free_words_o", 32'(free_words), 32'(e_free));
    end
    if (rst) begin
      m_rptr = 0; m_wptr = 0; m_done = 0; m_infl = 0; m_q.delete();
      armed = 1;
    end else begin
      if (e_valid && cmd_ready) void'(m_q.pop_front());
      if (m_infl) m_q.push_back(word_at(m_iaddr));
      if (wptr_we) begin
        m_wptr = int'(wptr_wdata[RAW-1:0]);
        m_done = wptr_wdata[31];
      end
      if (e_rd) begin
        m_iaddr = m_rptr;
        m_rptr  = (m_rptr + 1) % RING;
        m_infl  = 1;
      end else begin
        m_infl = 0;
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_wptr(input logic [31:0] v);
    @(posedge clk); #1;
    wptr_we = 1'b1; wptr_wdata = v;
    @(posedge clk); #1;
    wptr_we = 1'b0;
  endtask

  task automatic run_all();
    cycles(3);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "rptr after reset", 32'(rptr_o), 0);
    check("R1", "status after reset", status_o, 0);
    check("R1", "valid after reset", 32'(cmd_valid), 0);
    check("R9", "free on empty ring", 32'(free_words), 256);

    cmd_ready = 1'b1;
    write_wptr(32'd5);
    cycles(15);
    @(negedge clk);
    check("R3", "rptr after short burst", 32'(rptr_o), 5);
    check("R8", "status drained", status_o, 0);

    write_wptr(32'h7FFF_FF0A);
    @(negedge clk);
    check("R2", "high bits ignored", 32'(wptr_o), 32'h0A);
    check("R2", "flag clear", 32'(done_o), 0);
    cycles(15);
    write_wptr(32'h8000_000A);
    @(negedge clk);
    check("R2", "flag set", 32'(done_o), 1);
    cycles(3);
    @(negedge clk);
    check("R2", "flag-only write starts no fetch", 32'(mem_rd_en), 0);
    check("R2", "rptr unchanged by flag", 32'(rptr_o), 10);

    write_wptr(32'd60);
    for (int i = 0; i < 120; i++) begin
      @(posedge clk); #1;
      cmd_ready = (i % 3 != 0);
    end
    cmd_ready = 1'b1;
    cycles(30);
    @(negedge clk);
    check("R6", "rptr after throttled run", 32'(rptr_o), 60);
    check("R6", "queue empty after run", status_o, 0);

    cmd_ready = 1'b0;
    write_wptr(32'd120);
    cycles(40);
    @(negedge clk);
    check("R7", "queue full count", 32'(status_o[11:0]), 16);
    check("R7", "no read while full", 32'(mem_rd_en), 0);
    check("R7", "rptr stops at full", 32'(rptr_o), 76);
    check("R8", "busy and pending while stalled", 32'({status_o[31], status_o[16]}), 3);
    check("R9", "free words while stalled", 32'(free_words), 212);
    cmd_ready = 1'b1;
    cycles(100);
    @(negedge clk);
    check("R6", "rptr after drain", 32'(rptr_o), 120);

    write_wptr(32'd250);
    cycles(150);
    write_wptr(32'd3);
    cycles(30);
    @(negedge clk);
    check("R5", "rptr after wrap", 32'(rptr_o), 3);
    check("R9", "free after wrap", 32'(free_words), 256);

    cmd_ready = 1'b0;
    write_wptr(32'd200);
    cycles(10);
    rst = 1'b1;
    cycles(2);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "rptr after mid-stream reset", 32'(rptr_o), 0);
    check("R1", "wptr after mid-stream reset", 32'(wptr_o), 0);
    check("R1", "status after mid-stream reset", status_o, 0);
    check("R1", "valid after mid-stream reset", 32'(cmd_valid), 0);
    cmd_ready = 1'b1;
    write_wptr(32'd2);
    cycles(10);
    @(negedge clk);
    check("R4", "rptr after restart", 32'(rptr_o), 2);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule